// File: doc/BRIEF.md
# MDIO Management Master with PHY Discovery

This block drives the two-wire management bus of an Ethernet PHY using the classic 16-bit register frame. It makes the management clock by dividing the system clock, and it runs one read or one write each time a request is accepted. A single idle flag tells the surrounding logic when the bus is free. It is used during bring-up and link polling. The caller reads and writes PHY control and status registers through a flat request port. The 16-bit result of the last read stays on the read-data output until the next read finishes.

The divider ratio comes from a small table indexed by a 3-bit code. The system clock frequency given at elaboration sets the lowest code allowed, so the management clock never runs faster than its band permits. A discovery mode can replace fixed address wiring. When started, it sweeps the PHY addresses and reads both identifier registers at each one. It stops at the first address whose identifier matches the expected value. If no address matches, it repeats the whole sweep a bounded number of times and then raises a failure flag.

Top module: `mdio_scan_master`

## Requirements
- R1: Every frame is 64 bits, sent MSB first: 32 ones, start bits 01, opcode (01 write, 10 read), 5-bit PHY address, 5-bit register address, a 2-bit turnaround, then 16 data bits. On a write the master drives the turnaround as 10.
- R2: The MDC period in system clocks depends on the effective divider code: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 48, 4 gives 64, and 5, 6 or 7 give 96.
- R3: The effective code is the larger of `div_code_i` and a floor set by the SYS_CLK_HZ parameter. The floor is 0 up to 20 MHz, 1 up to 40 MHz, 2 up to 80 MHz, 3 up to 120 MHz, 4 up to 160 MHz and 5 up to 240 MHz. Any higher value stops elaboration.
- R4: A request is accepted only in a cycle where `idle_o` is high. `idle_o` falls in the next cycle and stays low until the frame has ended. A request or scan start seen while `idle_o` is low is ignored. If a request and a scan start arrive together, the request is taken.
- R5: On a read, `mdio_oe_o` is low for both turnaround bits and all 16 data bits. `rd_data_o` takes the 16 sampled data bits when the frame ends. A PHY that does not answer therefore reads as 0xFFFF.
- R6: `mdio_o` and `mdio_oe_o` change only at a falling edge of `mdc_o`. `mdio_i` is sampled at the rising edge.
- R7: A scan reads register 2 and then register 3 at PHY addresses 1, 2, … 30, in increasing order. `idle_o` stays low for the whole scan.
- R8: An address matches when its register 2 equals `exp_id_i[31:16]` and its register 3 AND 0xFFF0 equals `exp_id_i[15:0]` AND 0xFFF0. The scan stops at the first match and puts that address on `found_addr_o`.
- R9: A sweep with no match is repeated until SCAN_RETRIES sweeps have run (a value of 0 means one sweep). Then `scan_fail_o` is set and `found_addr_o` stays 0. A new scan clears both outputs.
- R10: After reset, `idle_o` is 1, `mdc_o`, `mdio_oe_o`, `rd_data_o`, `found_addr_o` and `scan_fail_o` are 0, and `mdio_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | 3 | Requested MDC divider code |
| req_valid_i | input | 1 | Transaction request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_phy_i | input | 5 | PHY address of the request |
| req_reg_i | input | 5 | Register address of the request |
| req_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Data of the last completed read |
| idle_o | output | 1 | Bus free, request may be accepted |
| scan_start_i | input | 1 | Starts a discovery scan |
| exp_id_i | input | 32 | Expected PHY identifier |
| found_addr_o | output | 5 | Matching PHY address, 0 if none |
| scan_fail_o | output | 1 | Scan finished without a match |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The main instance is built with SYS_CLK_HZ at 20 MHz, so every divider code can be reached, and with SCAN_RETRIES at 2. At the fastest divider, a full failing scan (two sweeps of 60 frames) fits comfortably in the run, and the bench can confirm that the second sweep restarts at address 1. A second instance is built at 100 MHz and only has its clock measured. This shows that codes below the band floor are raised to ratio 48 and that codes above the floor pass through unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned CODE_W     = 3;
  localparam int unsigned DCNT_W     = 7;
  localparam int unsigned PRE_LEN    = 32;
  localparam int unsigned FRAME_LEN  = 64;
  localparam int unsigned IDX_W      = $clog2(FRAME_LEN);
  localparam int unsigned TA_FIRST   = 46;
  localparam int unsigned DATA_FIRST = 48;

  localparam logic [1:0] SOF   = 2'b01;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] TA_WR = 2'b10;

  localparam logic [ADDR_W-1:0] ID_REG_HI  = 5'd2;
  localparam logic [ADDR_W-1:0] ID_REG_LO  = 5'd3;
  localparam logic [ADDR_W-1:0] SCAN_FIRST = 5'd1;
  localparam logic [ADDR_W-1:0] SCAN_LAST  = 5'd30;
  localparam logic [DATA_W-1:0] ID_LO_MASK = 16'hFFF0;

  typedef struct packed {
    logic              write;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;

  typedef enum logic [2:0] {
    SC_IDLE, SC_ISSUE_HI, SC_WAIT_HI, SC_ISSUE_LO, SC_WAIT_LO
  } scan_state_e;

  function automatic logic [CODE_W-1:0] band_code(longint unsigned hz);
    if (hz <= 64'd20_000_000)       return 3'd0;
    else if (hz <= 64'd40_000_000)  return 3'd1;
    else if (hz <= 64'd80_000_000)  return 3'd2;
    else if (hz <= 64'd120_000_000) return 3'd3;
    else if (hz <= 64'd160_000_000) return 3'd4;
    else                            return 3'd5;
  endfunction

  function automatic logic [DCNT_W-1:0] div_ratio(logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 7'd8;
      3'd1:    return 7'd16;
      3'd2:    return 7'd32;
      3'd3:    return 7'd48;
      3'd4:    return 7'd64;
      default: return 7'd96;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_pkg::*;
#(
  parameter logic [CODE_W-1:0] MIN_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] div_code_i,
  output logic              mdc_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [CODE_W-1:0] code_eff;
  logic [DCNT_W-1:0] ratio, half, cnt_q;
  logic              mdc_q;

  assign code_eff = (div_code_i < MIN_CODE) ? MIN_CODE : div_code_i;
  assign ratio    = div_ratio(code_eff);
  assign half     = ratio >> 1;
  assign fall_o   = (cnt_q >= ratio - 7'd1);
  assign rise_o   = (cnt_q == half - 7'd1);
  assign mdc_o    = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + 7'd1;
      if (fall_o)      mdc_q <= 1'b0;
      else if (rise_o) mdc_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_rise_i,
  input  logic              tick_fall_i,
  input  logic              start_i,
  input  mdio_req_t         req_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic                 busy_q, live_q, rd_q, done_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] shreg_q, frame_w;
  logic [DATA_W-1:0]    rsh_q, rdat_q;

  assign frame_w = {{PRE_LEN{1'b1}}, SOF,
                    req_i.write ? OP_WR : OP_RD,
                    req_i.phy, req_i.regad,
                    req_i.write ? TA_WR : 2'b11,
                    req_i.write ? req_i.wdata : {DATA_W{1'b1}}};

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rd_data_o = rdat_q;
  assign mdio_o    = live_q ? shreg_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = live_q && !(rd_q && (idx_q >= IDX_W'(TA_FIRST)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      live_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      shreg_q <= '1;
      rsh_q   <= '0;
      rdat_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        live_q  <= 1'b0;
        rd_q    <= !req_i.write;
        shreg_q <= frame_w;
        idx_q   <= '0;
      end else if (busy_q && tick_fall_i) begin
        if (!live_q) begin
          live_q <= 1'b1;                      // first bit goes out here
        end else if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
          busy_q <= 1'b0;
          live_q <= 1'b0;
          done_q <= 1'b1;
          if (rd_q) rdat_q <= rsh_q;
        end else begin
          idx_q   <= idx_q + 1'b1;
          shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b1};
        end
      end
      if (live_q && rd_q && tick_rise_i && (idx_q >= IDX_W'(DATA_FIRST)))
        rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_phy_scan.sv
module mdio_phy_scan
  import mdio_pkg::*;
#(
  parameter int unsigned SCAN_RETRIES = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       exp_id_i,
  input  logic              eng_done_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output logic              active_o,
  output logic              go_o,
  output mdio_req_t         req_o,
  output logic [ADDR_W-1:0] found_o,
  output logic              fail_o
);
  localparam int unsigned PASSES = (SCAN_RETRIES == 0) ? 1 : SCAN_RETRIES;
  localparam int unsigned PW     = $clog2(PASSES + 1);

  scan_state_e       state_q;
  logic [ADDR_W-1:0] addr_q, found_q;
  logic [PW-1:0]     pass_q;
  logic [31:0]       exp_q;
  logic [DATA_W-1:0] hi_q;
  logic              fail_q, hit;

  assign active_o = (state_q != SC_IDLE);
  assign go_o     = (state_q == SC_ISSUE_HI) || (state_q == SC_ISSUE_LO);
  assign req_o    = '{write: 1'b0, phy: addr_q,
                      regad: (state_q == SC_ISSUE_HI) ? ID_REG_HI : ID_REG_LO,
                      wdata: '0};
  assign found_o  = found_q;
  assign fail_o   = fail_q;
  assign hit      = (hi_q == exp_q[31:16]) &&
                    ((eng_rdata_i & ID_LO_MASK) == (exp_q[15:0] & ID_LO_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SC_IDLE;
      addr_q  <= SCAN_FIRST;
      found_q <= '0;
      pass_q  <= '0;
      exp_q   <= '0;
      hi_q    <= '0;
      fail_q  <= 1'b0;
    end else begin
      case (state_q)
        SC_IDLE: if (start_i) begin
          addr_q  <= SCAN_FIRST;
          pass_q  <= '0;
          found_q <= '0;
          fail_q  <= 1'b0;
          exp_q   <= exp_id_i;
          state_q <= SC_ISSUE_HI;
        end
        SC_ISSUE_HI: state_q <= SC_WAIT_HI;
        SC_WAIT_HI: if (eng_done_i) begin
          hi_q    <= eng_rdata_i;
          state_q <= SC_ISSUE_LO;
        end
        SC_ISSUE_LO: state_q <= SC_WAIT_LO;
        SC_WAIT_LO: if (eng_done_i) begin
          if (hit) begin
            found_q <= addr_q;
            state_q <= SC_IDLE;
          end else if (addr_q == SCAN_LAST) begin
            if (pass_q == PW'(PASSES - 1)) begin
              fail_q  <= 1'b1;
              state_q <= SC_IDLE;
            end else begin
              pass_q  <= pass_q + 1'b1;
              addr_q  <= SCAN_FIRST;
              state_q <= SC_ISSUE_HI;
            end
          end else begin
            addr_q  <= addr_q + 1'b1;
            state_q <= SC_ISSUE_HI;
          end
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_scan_master.sv
module mdio_scan_master
  import mdio_pkg::*;
#(
  parameter longint unsigned SYS_CLK_HZ   = 100_000_000,
  parameter int unsigned     SCAN_RETRIES = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_phy_i,
  input  logic [ADDR_W-1:0] req_reg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              idle_o,
  input  logic              scan_start_i,
  input  logic [31:0]       exp_id_i,
  output logic [ADDR_W-1:0] found_addr_o,
  output logic              scan_fail_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam logic [CODE_W-1:0] MIN_CODE = band_code(SYS_CLK_HZ);

  if (SYS_CLK_HZ > 64'd240_000_000) begin : g_clk_guard
    $error("mdio_scan_master: system clock above 240 MHz is not supported");
  end

  logic      tick_rise, tick_fall, eng_busy, eng_done, eng_start;
  logic      user_go, scan_go, scan_active, scan_issue;
  mdio_req_t user_req, scan_req, eng_req;

  assign idle_o    = !eng_busy && !scan_active;
  assign user_go   = req_valid_i && idle_o;
  assign scan_go   = scan_start_i && idle_o && !req_valid_i;
  assign user_req  = '{write: req_write_i, phy: req_phy_i,
                       regad: req_reg_i, wdata: req_wdata_i};
  assign eng_req   = scan_active ? scan_req : user_req;
  assign eng_start = user_go || scan_issue;

  mdio_clk_gen #(.MIN_CODE(MIN_CODE)) i_clk_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_code_i (div_code_i),
    .mdc_o      (mdc_o),
    .rise_o     (tick_rise),
    .fall_o     (tick_fall)
  );

  mdio_frame_engine i_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_rise_i (tick_rise),
    .tick_fall_i (tick_fall),
    .start_i     (eng_start),
    .req_i       (eng_req),
    .busy_o      (eng_busy),
    .done_o      (eng_done),
    .rd_data_o   (rd_data_o),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o),
    .mdio_i      (mdio_i)
  );

  mdio_phy_scan #(.SCAN_RETRIES(SCAN_RETRIES)) i_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (scan_go),
    .exp_id_i    (exp_id_i),
    .eng_done_i  (eng_done),
    .eng_rdata_i (rd_data_o),
    .active_o    (scan_active),
    .go_o        (scan_issue),
    .req_o       (scan_req),
    .found_o     (found_addr_o),
    .fail_o      (scan_fail_o)
  );
endmodule

// File: rtl/mdio_scan_master_chk.sv
module mdio_scan_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       idle_o,
  input logic       mdc_o,
  input logic       mdio_o,
  input logic       mdio_oe_o,
  input logic [4:0] found_addr_o,
  input logic       scan_fail_o
);
  AST_ACCEPT_DROPS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && idle_o |=> !idle_o); // R4
  AST_IDLE_BUS_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mdio_oe_o); // R4
  AST_MDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $fell(mdc_o)); // R6
  AST_OE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_oe_o) |-> $fell(mdc_o)); // R6
  AST_FOUND_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_addr_o != 5'd0) |-> (found_addr_o <= 5'd30)); // R8
  AST_FAIL_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_fail_o |-> (found_addr_o == 5'd0)); // R9
endmodule

bind mdio_scan_master mdio_scan_master_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .idle_o       (idle_o),
  .mdc_o        (mdc_o),
  .mdio_o       (mdio_o),
  .mdio_oe_o    (mdio_oe_o),
  .found_addr_o (found_addr_o),
  .scan_fail_o  (scan_fail_o)
);

// File: tb/test_mdio_scan_master.sv
module test_mdio_scan_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0]  PHY_AT = 5'd9;
  localparam logic [15:0] ID_HI  = 16'h0022;
  localparam logic [15:0] ID_LO  = 16'h1562;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  div_code = 3'd0, div_code_f = 3'd0;
  logic        req_valid = 1'b0, req_write = 1'b0, scan_start = 1'b0;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0, rd_data, rd_data_f;
  logic [31:0] exp_id = '0;
  logic        idle, scan_fail, mdc, mdo, mdo_oe;
  logic        idle_f, scan_fail_f, mdc_f, mdo_f, mdo_oe_f;
  logic [4:0]  found, found_f;
  logic        mdio_in = 1'b1;

  mdio_scan_master #(.SYS_CLK_HZ(20_000_000), .SCAN_RETRIES(2)) i_mdio_scan_master (
    .clk_i(clk), .rst_ni(rst_n), .div_code_i(div_code),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_phy_i(req_phy),
    .req_reg_i(req_reg), .req_wdata_i(req_wdata), .rd_data_o(rd_data),
    .idle_o(idle), .scan_start_i(scan_start), .exp_id_i(exp_id),
    .found_addr_o(found), .scan_fail_o(scan_fail), .mdc_o(mdc),
    .mdio_o(mdo), .mdio_oe_o(mdo_oe), .mdio_i(mdio_in)
  );

  mdio_scan_master #(.SYS_CLK_HZ(100_000_000), .SCAN_RETRIES(0)) i_mdio_scan_master_fast (
    .clk_i(clk), .rst_ni(rst_n), .div_code_i(div_code_f),
    .req_valid_i(1'b0), .req_write_i(1'b0), .req_phy_i(5'd0),
    .req_reg_i(5'd0), .req_wdata_i(16'd0), .rd_data_o(rd_data_f),
    .idle_o(idle_f), .scan_start_i(1'b0), .exp_id_i(32'd0),
    .found_addr_o(found_f), .scan_fail_o(scan_fail_f), .mdc_o(mdc_f),
    .mdio_o(mdo_f), .mdio_oe_o(mdo_oe_f), .mdio_i(1'b1)
  );

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- PHY model ----------------
  int          ones = 0, phase = 0, hcnt = 0, dcnt = 0, n_frames = 0;
  logic [11:0] hdr;
  logic [17:0] w18;
  logic [15:0] rdv;
  logic        drv, next_val = 1'b1;
  int          rd_oe_bad = 0;
  logic [1:0]  last_op, last_ta;
  logic [4:0]  last_phy, last_reg;
  logic [15:0] last_wdata;
  logic [4:0]  log_phy [0:255];
  logic [4:0]  log_reg [0:255];

  function automatic logic [15:0] reg_val(input logic [4:0] r);
    if (r == 5'd2) return ID_HI;
    if (r == 5'd3) return ID_LO;
    return 16'h1000 | {11'd0, r};
  endfunction

  always @(negedge mdc) mdio_in = next_val;

  always @(posedge mdc) begin
    case (phase)
      0: begin
        if (mdo_oe && mdo) ones++;
        else if (mdo_oe && !mdo && ones >= 32) phase = 1;
        else ones = 0;
      end
      1: begin
        if (mdo_oe && mdo) begin phase = 2; hcnt = 0; end
        else begin phase = 0; ones = 0; end
      end
      2: begin
        hdr = {hdr[10:0], mdo};
        hcnt++;
        if (hcnt == 12) begin
          last_op = hdr[11:10]; last_phy = hdr[9:5]; last_reg = hdr[4:0];
          if (n_frames < 256) begin
            log_phy[n_frames] = hdr[9:5];
            log_reg[n_frames] = hdr[4:0];
          end
          n_frames++;
          dcnt = 0;
          if (hdr[11:10] == 2'b10) begin
            phase = 3;
            drv = (hdr[9:5] == PHY_AT);
            rdv = drv ? reg_val(hdr[4:0]) : 16'hFFFF;
            next_val = 1'b1;
          end else begin
            phase = 4;
          end
        end
      end
      3: begin
        dcnt++;
        if (mdo_oe) rd_oe_bad++;
        if (dcnt == 1) next_val = drv ? 1'b0 : 1'b1;
        else if (dcnt <= 17) next_val = drv ? rdv[17-dcnt] : 1'b1;
        else begin next_val = 1'b1; phase = 0; ones = 0; end
      end
      4: begin
        dcnt++;
        w18 = {w18[16:0], mdo};
        if (dcnt == 18) begin
          last_ta = w18[17:16]; last_wdata = w18[15:0];
          phase = 0; ones = 0;
        end
      end
      default: phase = 0;
    endcase
  end

  // MDIO output may only move together with an MDC fall (R6)
  logic prev_mdc = 1'b0, prev_mdo = 1'b1, prev_oe = 1'b0;
  int   edge_bad = 0;
  always @(negedge clk) begin
    if (rst_n && ((mdo != prev_mdo) || (mdo_oe != prev_oe)) && !(prev_mdc && !mdc))
      edge_bad++;
    prev_mdc = mdc; prev_mdo = mdo; prev_oe = mdo_oe;
  end

  // ---------------- helpers ----------------
  task automatic measure(input bit fast, output int period);
    time t0;
    if (fast) begin @(posedge mdc_f); @(posedge mdc_f); t0 = $time; @(posedge mdc_f); end
    else      begin @(posedge mdc);   @(posedge mdc);   t0 = $time; @(posedge mdc);   end
    period = int'(($time - t0) / CLK_PERIOD);
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (!idle && cycles < 100000) begin @(negedge clk); cycles++; end
  endtask

  task automatic issue(input bit wr, input logic [4:0] phy, input logic [4:0] r,
                       input logic [15:0] d, output int busy_cycles);
    @(negedge clk);
    chk(idle == 1'b1, "R4 idle before request", {31'd0, idle}, 1);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(idle == 1'b0, "R4 idle drops after accept", {31'd0, idle}, 0);
    wait_idle(busy_cycles);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(idle == 1'b1 && idle_f == 1'b1, "R10 idle after reset", {31'd0, idle}, 1);
    chk(rd_data == 16'd0, "R10 rd_data after reset", rd_data, 0);
    chk(found == 5'd0 && scan_fail == 1'b0, "R10 scan outputs after reset", {found, scan_fail}, 0);
    chk(mdo_oe == 1'b0 && mdo == 1'b1 && mdc == 1'b0, "R10 bus after reset", {mdc, mdo, mdo_oe}, 3'b010);
  endtask

  task automatic t_divider;
    int p;
    div_code = 3'd0; measure(0, p); chk(p == 8,  "R2 code0 period", p, 8);
    div_code = 3'd1; measure(0, p); chk(p == 16, "R2 code1 period", p, 16);
    div_code = 3'd5; measure(0, p); chk(p == 96, "R2 code5 period", p, 96);
    div_code = 3'd7; measure(0, p); chk(p == 96, "R2 code7 period", p, 96);
    div_code = 3'd0; measure(0, p);
    div_code_f = 3'd0; measure(1, p); chk(p == 48, "R3 code0 raised to floor", p, 48);
    div_code_f = 3'd2; measure(1, p); chk(p == 48, "R3 code2 raised to floor", p, 48);
    div_code_f = 3'd4; measure(1, p); chk(p == 64, "R3 code4 above floor", p, 64);
  endtask

  task automatic t_write;
    int bc, f0;
    f0 = n_frames;
    issue(1'b1, 5'd9, 5'd4, 16'hA5C3, bc);
    chk(bc >= 512, "R4 idle low for whole write", bc, 512);
    chk(n_frames == f0 + 1, "R1 one write frame", n_frames - f0, 1);
    chk(last_op == 2'b01, "R1 write opcode", last_op, 2'b01);
    chk(last_phy == 5'd9 && last_reg == 5'd4, "R1 write addresses", {last_phy, last_reg}, {5'd9, 5'd4});
    chk(last_ta == 2'b10, "R1 write turnaround", last_ta, 2'b10);
    chk(last_wdata == 16'hA5C3, "R1 write data", last_wdata, 16'hA5C3);
  endtask

  task automatic t_read;
    int bc;
    rd_oe_bad = 0;
    issue(1'b0, PHY_AT, 5'd2, 16'h0, bc);
    chk(last_op == 2'b10, "R1 read opcode", last_op, 2'b10);
    chk(rd_data == ID_HI, "R5 read id hi", rd_data, ID_HI);
    issue(1'b0, PHY_AT, 5'd7, 16'h0, bc);
    chk(rd_data == 16'h1007, "R5 read reg 7", rd_data, 16'h1007);
    issue(1'b0, 5'd3, 5'd2, 16'h0, bc);
    chk(rd_data == 16'hFFFF, "R5 absent phy reads ones", rd_data, 16'hFFFF);
    chk(rd_oe_bad == 0, "R5 output released in turnaround and data", rd_oe_bad, 0);
  endtask

  task automatic t_busy_ignore;
    int bc, f0;
    f0 = n_frames;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_phy = 5'd9; req_reg = 5'd4; req_wdata = 16'h1111;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_reg = 5'd6; req_wdata = 16'h2222; scan_start = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; scan_start = 1'b0;
    wait_idle(bc);
    repeat (40) @(negedge clk);
    chk(n_frames == f0 + 1, "R4 busy request ignored", n_frames - f0, 1);
    chk(last_reg == 5'd4 && last_wdata == 16'h1111, "R4 first request kept", last_wdata, 16'h1111);
    chk(idle == 1'b1 && found == 5'd0 && scan_fail == 1'b0, "R4 busy scan start ignored",
        {idle, found, scan_fail}, {1'b1, 6'd0});
  endtask

  task automatic t_scan_hit;
    int bc, f0;
    bit ord_ok;
    f0 = n_frames;
    exp_id = {ID_HI, ID_LO ^ 16'h000F};
    @(negedge clk); scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    chk(idle == 1'b0, "R7 idle low once scan starts", {31'd0, idle}, 0);
    wait_idle(bc);
    chk(found == PHY_AT, "R8 found address with masked low nibble", found, PHY_AT);
    chk(scan_fail == 1'b0, "R8 no fail on hit", {31'd0, scan_fail}, 0);
    chk(n_frames - f0 == 18, "R8 scan stops at first match", n_frames - f0, 18);
    ord_ok = 1'b1;
    for (int k = 0; k < 18; k++)
      if (log_phy[f0+k] != 5'(k/2 + 1) || log_reg[f0+k] != ((k % 2 == 0) ? 5'd2 : 5'd3))
        ord_ok = 1'b0;
    chk(ord_ok, "R7 address and register order", {31'd0, ord_ok}, 1);
    chk(bc >= 18*512, "R7 idle low for whole scan", bc, 18*512);
  endtask

  task automatic t_scan_fail;
    int bc, f0;
    f0 = n_frames;
    exp_id = {ID_HI, 16'h1572};
    @(negedge clk); scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
    chk(found == 5'd0, "R9 new scan clears found", found, 0);
    wait_idle(bc);
    chk(scan_fail == 1'b1, "R9 fail after all sweeps", {31'd0, scan_fail}, 1);
    chk(found == 5'd0, "R9 no address on fail", found, 0);
    chk(n_frames - f0 == 120, "R9 two sweeps of 60 frames", n_frames - f0, 120);
    chk(log_phy[f0+60] == 5'd1 && log_reg[f0+60] == 5'd2, "R7 second sweep restarts at 1",
        {log_phy[f0+60], log_reg[f0+60]}, {5'd1, 5'd2});
    chk(log_phy[f0+59] == 5'd30 && log_reg[f0+59] == 5'd3, "R7 sweep ends at 30",
        {log_phy[f0+59], log_reg[f0+59]}, {5'd30, 5'd3});
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_divider();
    t_write();
    t_read();
    t_busy_ignore();
    t_scan_hit();
    t_scan_fail();
    chk(edge_bad == 0, "R6 data moves only on MDC fall", edge_bad, 0);
    finish_run();
  end
endmodule